// File: doc/BRIEF.md
# Rail Fault Supervisor with Undervoltage Latch

This block sits between the digitized protection comparators of a multi-rail panel power supply and the rail controllers. Every cycle it takes per-rail overvoltage detect and release flags, undervoltage flags, overcurrent flags and the global thermal and input-undervoltage flags, and applies one protection policy. Thresholds and hysteresis are resolved before these flags reach the block.

Overvoltage and over-temperature are self-clearing faults with hysteresis. Each one is set by its detect flag and cleared only by its release flag. Undervoltage is handled by a timer-latch. A millisecond tick advances a per-rail timer while the rail is enabled, past soft start and reporting undervoltage. While that timer runs, a buck rail is asked to divide its switching frequency by four. If the timer reaches its limit, every output is latched off. The latch stays until the power-on reset is asserted again, and a sticky register keeps a record of which rails caused it. Overcurrent is only passed through to the rail controller as a current-limit indication.

Top module: `rail_fault_supervisor`

## Requirements
- R1: A rail's `sw_stop` bit goes high the cycle after its `ov_det` bit is sampled high. It stays high until `ov_rel` is sampled, and goes low the cycle after that. When detect and release are sampled together, detect wins.
- R2: `therm_hot` sampled high sets `all_off` and every `sw_stop` bit from the next cycle. They stay set until `therm_cool` is sampled, and clear the cycle after.
- R3: While `vin_uvlo` is high, `all_off` and all `sw_stop` bits are high in the same cycle, and no undervoltage timer advances.
- R4: A rail's timer counts `ms_tick` pulses sampled while its `uv_flag` and `rail_active` bits are both high. At the edge that samples the UV_LIMIT_MS-th such pulse, `uv_latched` rises. For the negative rail, `uv_flag` means its magnitude is below 80% of target.
- R5: If the condition drops for a single cycle before expiry, the timer returns to zero. A later fault then needs the full UV_LIMIT_MS ticks.
- R6: A rail whose `rail_active` bit is low never advances its timer, whatever its `uv_flag` says.
- R7: `freq_div4[i]` is high only when rail i is a buck rail (bit i of BUCK_MASK set; by default rails 0 to 2) whose timer condition holds and the latch is not set. Non-buck rails always read 0.
- R8: Once latched, `all_off` and all `sw_stop` bits stay high and `freq_div4` stays 0. Flags, `rail_active` and thermal release have no effect on this. Only `rst_n` low clears the latch.
- R9: Bit i of `uv_cause` is set for every rail whose timer expires on the latching edge. Rails that expire on the same edge are all recorded, and the register is frozen afterwards.
- R10: `oc_limit` equals `oc_flag` in the same cycle.
- R11: After reset, `sw_stop`, `freq_div4`, `uv_cause`, `all_off` and `uv_latched` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; the only way to clear the latch |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| ov_det | input | NUM_RAILS | Overvoltage detect flag per rail |
| ov_rel | input | NUM_RAILS | Overvoltage release flag per rail |
| uv_flag | input | NUM_RAILS | Undervoltage flag per rail |
| oc_flag | input | NUM_RAILS | Overcurrent flag per rail |
| rail_active | input | NUM_RAILS | Rail enabled and past soft start |
| therm_hot | input | 1 | Die above the thermal trip point |
| therm_cool | input | 1 | Die below the thermal restart point |
| vin_uvlo | input | 1 | Input supply below its lockout level |
| sw_stop | output | NUM_RAILS | Stop switching, per rail |
| freq_div4 | output | NUM_RAILS | Divide switching frequency by four, per rail |
| oc_limit | output | NUM_RAILS | Current-limit indication, per rail |
| all_off | output | 1 | Global shutdown of every output |
| uv_latched | output | 1 | Undervoltage latch state |
| uv_cause | output | NUM_RAILS | Sticky record of the rails that tripped the latch |

## Verification
Two undervoltage timers can expire on the same millisecond tick. The bench provokes this by starting rail 0 (a buck rail) and rail 4 (a boost-side rail) into fault together and feeding them the same ticks. It then requires both cause bits to be set at once and the latch to rise on exactly the tenth tick, not the ninth. The bench also releases the thermal fault, the overvoltage faults and the rail activity while the latch is held. It then checks that shutdown is still in force and that the cause record has not moved.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
   localparam int unsigned RSUP_MAX_RAILS = 32;
   localparam int unsigned RSUP_MIN_LIMIT = 2;

   typedef enum logic {
      HY_CLEAR   = 1'b0,
      HY_TRIPPED = 1'b1
   } hyst_state_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/rsup_hyst.sv
module rsup_hyst
   import rsup_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic state_o
);
   hyst_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (set_i)
         state_d = HY_TRIPPED;
      else if (clr_i)
         state_d = HY_CLEAR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= HY_CLEAR;
      else
         state_q <= state_d;
   end

   assign state_o = (state_q == HY_TRIPPED);
endmodule

// File: rtl/rsup_uv_timer.sv
module rsup_uv_timer
   import rsup_pkg::*;
#(
   parameter int unsigned LIMIT   = 10,
   parameter bit          IS_BUCK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic arm_i,
   input  logic freeze_i,
   output logic expire_o,
   output logic div4_o
);
   localparam int unsigned CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          running;

   assign running  = arm_i && !freeze_i;
   assign expire_o = running && tick_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!running)
         cnt_q <= '0;
      else if (tick_i && (cnt_q != LAST))
         cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (IS_BUCK) begin : g_buck
         assign div4_o = running;
      end else begin : g_nobuck
         assign div4_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rsup_latch.sv
module rsup_latch #(
   parameter int unsigned NUM_RAILS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RAILS-1:0] expire_i,
   output logic                 latched_o,
   output logic [NUM_RAILS-1:0] cause_o
);
   logic                 lat_q;
   logic [NUM_RAILS-1:0] cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q   <= 1'b0;
         cause_q <= '0;
      end else if (!lat_q && (|expire_i)) begin
         lat_q   <= 1'b1;
         cause_q <= expire_i;
      end
   end

   assign latched_o = lat_q;
   assign cause_o   = cause_q;
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
   import rsup_pkg::*;
#(
   parameter int unsigned          NUM_RAILS   = 6,
   parameter int unsigned          UV_LIMIT_MS = 10,
   parameter logic [NUM_RAILS-1:0] BUCK_MASK   = 6'b000111
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ms_tick,
   input  logic [NUM_RAILS-1:0] ov_det,
   input  logic [NUM_RAILS-1:0] ov_rel,
   input  logic [NUM_RAILS-1:0] uv_flag,
   input  logic [NUM_RAILS-1:0] oc_flag,
   input  logic [NUM_RAILS-1:0] rail_active,
   input  logic                 therm_hot,
   input  logic                 therm_cool,
   input  logic                 vin_uvlo,
   output logic [NUM_RAILS-1:0] sw_stop,
   output logic [NUM_RAILS-1:0] freq_div4,
   output logic [NUM_RAILS-1:0] oc_limit,
   output logic                 all_off,
   output logic                 uv_latched,
   output logic [NUM_RAILS-1:0] uv_cause
);
   generate
      if (NUM_RAILS < 1 || NUM_RAILS > RSUP_MAX_RAILS) begin : g_bad_rails
         $error("rail_fault_supervisor: NUM_RAILS out of range");
      end
      if (UV_LIMIT_MS < RSUP_MIN_LIMIT) begin : g_bad_limit
         $error("rail_fault_supervisor: UV_LIMIT_MS too small");
      end
   endgenerate

   logic [NUM_RAILS-1:0] ov_state;
   logic [NUM_RAILS-1:0] expire;
   logic [NUM_RAILS-1:0] arm;
   logic                 therm_state;
   logic                 latched;

   rsup_hyst u_therm (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (therm_hot),
      .clr_i   (therm_cool),
      .state_o (therm_state)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_RAILS; gi++) begin : g_rail
         assign arm[gi] = uv_flag[gi] && rail_active[gi] && !vin_uvlo;

         rsup_hyst u_ov (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (ov_det[gi]),
            .clr_i   (ov_rel[gi]),
            .state_o (ov_state[gi])
         );

         rsup_uv_timer #(
            .LIMIT   (UV_LIMIT_MS),
            .IS_BUCK (BUCK_MASK[gi])
         ) u_uvt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (ms_tick),
            .arm_i    (arm[gi]),
            .freeze_i (latched),
            .expire_o (expire[gi]),
            .div4_o   (freq_div4[gi])
         );
      end
   endgenerate

   rsup_latch #(.NUM_RAILS(NUM_RAILS)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire_i  (expire),
      .latched_o (latched),
      .cause_o   (uv_cause)
   );

   assign all_off    = latched || therm_state || vin_uvlo;
   assign sw_stop    = ov_state | {NUM_RAILS{all_off}};
   assign oc_limit   = oc_flag;
   assign uv_latched = latched;
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
   parameter int unsigned          NUM_RAILS = 6,
   parameter logic [NUM_RAILS-1:0] BUCK_MASK = 6'b000111
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_RAILS-1:0] ov_det,
   input logic [NUM_RAILS-1:0] uv_flag,
   input logic                 therm_hot,
   input logic                 vin_uvlo,
   input logic [NUM_RAILS-1:0] sw_stop,
   input logic [NUM_RAILS-1:0] freq_div4,
   input logic                 all_off,
   input logic                 uv_latched,
   input logic [NUM_RAILS-1:0] uv_cause
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_RAILS; gi++) begin : g_chk
         assert_ov_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ov_det[gi] |=> sw_stop[gi]);
         assert_div_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            freq_div4[gi] |-> (uv_flag[gi] && !uv_latched));
      end
   endgenerate

   assert_therm_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      therm_hot |=> all_off);
   assert_uvlo_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vin_uvlo |-> (all_off && (&sw_stop)));
   assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      uv_latched |=> (uv_latched && all_off));
   assert_cause_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uv_latched |-> (uv_cause != '0));
   assert_cause_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_latched && $past(uv_latched)) |-> $stable(uv_cause));
endmodule

bind rail_fault_supervisor rsup_checker #(
   .NUM_RAILS (NUM_RAILS),
   .BUCK_MASK (BUCK_MASK)
) u_rsup_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ov_det     (ov_det),
   .uv_flag    (uv_flag),
   .therm_hot  (therm_hot),
   .vin_uvlo   (vin_uvlo),
   .sw_stop    (sw_stop),
   .freq_div4  (freq_div4),
   .all_off    (all_off),
   .uv_latched (uv_latched),
   .uv_cause   (uv_cause)
);

// File: tb/rail_fault_supervisor_test.sv
module rail_fault_supervisor_test;
   localparam int CLK_PERIOD = 10;
   localparam int N = 6;
   localparam int LIM = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic [N-1:0] ov_det = '0, ov_rel = '0, uv_flag = '0, oc_flag = '0, rail_active = '0;
   logic therm_hot = 1'b0, therm_cool = 1'b0, vin_uvlo = 1'b0;
   logic [N-1:0] sw_stop, freq_div4, oc_limit, uv_cause;
   logic all_off, uv_latched;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rail_fault_supervisor #(.NUM_RAILS(N), .UV_LIMIT_MS(LIM), .BUCK_MASK(6'b000111)) uut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ov_det(ov_det), .ov_rel(ov_rel),
      .uv_flag(uv_flag), .oc_flag(oc_flag), .rail_active(rail_active),
      .therm_hot(therm_hot), .therm_cool(therm_cool), .vin_uvlo(vin_uvlo),
      .sw_stop(sw_stop), .freq_div4(freq_div4), .oc_limit(oc_limit),
      .all_off(all_off), .uv_latched(uv_latched), .uv_cause(uv_cause));

   // det, rel, oc, expected sw_stop, expected oc_limit
   typedef struct packed {
      logic [N-1:0] det;
      logic [N-1:0] rel;
      logic [N-1:0] oc;
      logic [N-1:0] stop;
      logic [N-1:0] lim;
   } vec_t;

   localparam vec_t OV_TABLE [6] = '{
      '{6'b000001, 6'b000000, 6'b000000, 6'b000001, 6'b000000},
      '{6'b000000, 6'b000000, 6'b001000, 6'b000001, 6'b001000},
      '{6'b000000, 6'b000001, 6'b000000, 6'b000000, 6'b000000},
      '{6'b100000, 6'b100000, 6'b000000, 6'b100000, 6'b000000},
      '{6'b000010, 6'b100000, 6'b000000, 6'b000010, 6'b000000},
      '{6'b000000, 6'b000010, 6'b010100, 6'b000000, 6'b010100}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R11 reset state
      check("R11 sw_stop", 32'(sw_stop), 0);
      check("R11 freq_div4", 32'(freq_div4), 0);
      check("R11 uv_cause", 32'(uv_cause), 0);
      check("R11 all_off", 32'(all_off), 0);
      check("R11 uv_latched", 32'(uv_latched), 0);
      rst_n = 1'b1;

      // R1 / R10 table walk
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         ov_det = OV_TABLE[i].det; ov_rel = OV_TABLE[i].rel; oc_flag = OV_TABLE[i].oc;
         #1 check("R10 oc_limit", 32'(oc_limit), 32'(OV_TABLE[i].lim));
         @(negedge clk);
         check("R1 sw_stop", 32'(sw_stop), 32'(OV_TABLE[i].stop));
         ov_det = '0; ov_rel = '0; oc_flag = '0;
      end

      // R2 thermal hysteresis
      @(negedge clk) therm_hot = 1'b1;
      @(negedge clk) therm_hot = 1'b0;
      check("R2 all_off set", 32'(all_off), 1);
      check("R2 sw_stop all", 32'(sw_stop), 32'h3f);
      @(negedge clk);
      check("R2 held", 32'(all_off), 1);
      therm_cool = 1'b1;
      @(negedge clk) therm_cool = 1'b0;
      check("R2 released", 32'(all_off), 0);

      // R3 input lockout is immediate and blocks timers
      vin_uvlo = 1'b1; rail_active = 6'b000001; uv_flag = 6'b000001;
      #1 check("R3 all_off", 32'(all_off), 1);
      check("R3 sw_stop", 32'(sw_stop), 32'h3f);
      for (int k = 0; k < LIM + 2; k++) tick();
      check("R3 no latch", 32'(uv_latched), 0);
      @(negedge clk) vin_uvlo = 1'b0;

      // R5: nine ticks, one-cycle drop, then nine more: no latch
      for (int k = 0; k < LIM - 1; k++) tick();
      check("R7 div4 buck rail", 32'(freq_div4), 32'h01);
      @(negedge clk) uv_flag = '0;
      @(negedge clk) uv_flag = 6'b000001;
      for (int k = 0; k < LIM - 1; k++) tick();
      check("R5 timer restarted", 32'(uv_latched), 0);

      // R6: inactive rail never counts; R7 inactive buck shows no divide
      @(negedge clk) uv_flag = 6'b000010; rail_active = 6'b000000;
      for (int k = 0; k < LIM + 2; k++) tick();
      check("R6 inactive no latch", 32'(uv_latched), 0);
      check("R7 inactive no div", 32'(freq_div4), 0);

      // R4/R7/R9: rails 0 and 4 expire on the same tick
      @(negedge clk) uv_flag = 6'b010001; rail_active = 6'b010001;
      for (int k = 0; k < LIM - 1; k++) tick();
      check("R4 not yet at limit-1", 32'(uv_latched), 0);
      check("R7 non-buck no div", 32'(freq_div4), 32'h01);
      tick();
      check("R4 latched at limit", 32'(uv_latched), 1);
      check("R9 both causes", 32'(uv_cause), 32'h11);
      check("R8 all_off", 32'(all_off), 1);
      check("R8 div cleared", 32'(freq_div4), 0);

      // R8: clearing everything has no effect on the latch
      uv_flag = '0; rail_active = '0; ov_rel = '1; therm_cool = 1'b1;
      for (int k = 0; k < 3; k++) tick();
      ov_rel = '0; therm_cool = 1'b0;
      check("R8 stays latched", 32'(uv_latched), 1);
      check("R8 sw_stop held", 32'(sw_stop), 32'h3f);
      check("R9 cause frozen", 32'(uv_cause), 32'h11);

      // R8/R11: only reset clears
      do_reset();
      check("R8 reset clears latch", 32'(uv_latched), 0);
      check("R11 cause cleared", 32'(uv_cause), 0);
      check("R11 all_off cleared", 32'(all_off), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule